// File: doc/BRIEF.md
# RS Self-Test Pattern and Gate Generator

This block is a self-test source for a Reed-Solomon encoder that takes one serial message bit per clock. It produces three outputs: a serial test message, a gate that marks where the message ends and the encoder's parity begins, and a ready flag. The gate stays high while 223×I message bytes go out and then stays low for the 32×I byte times that the encoder needs to send its parity. Here I is the interleave depth, chosen with the same two-bit select that the encoder uses.

A three-bit code selects one of four fixed byte patterns. Each pattern is built from zeros and a few marker bytes, and where the markers sit depends on I. The block runs from the encoder's bit clock and sends one bit per cycle, most significant bit first. It holds the message output at zero whenever the gate is low, so the output can drive the encoder's data input directly. The depth select and the pattern code are sampled at the start of every block and held until that block, parity included, has finished.

The ready flag stays low through the first full gate period after reset. The encoder's parity state is not cleared by reset, so that first period works as a flush.

Top module: `rs_selftest_gen`

## Requirements
- R1: The gate is high for exactly 223×I×8 clocks and then low for exactly 32×I×8 clocks, and this repeats. It first goes high on the first clock edge after reset is released.
- R2: The interleave depth I is decoded from depth_sel as 00→5, 01→4, 10→1, 11→5. depth_sel and pat_sel are sampled only when a block starts, so a change made in the middle of a block first takes effect at the next rise of the gate.
- R3: Message bytes are sent one bit per clock, most significant bit first. test_msg is 0 on every clock where the gate is low.
- R4: With pat_sel=001, byte number b of the block (counting from 0) is (b mod I)+1. The block is therefore 223 repetitions of 1..I.
- R5: With pat_sel=010, every byte is 00 except the last one of the block, which is 7B.
- R6: With pat_sel=011, the first 222×I bytes are 00. The last I bytes are the first I entries of the list 7B, AF, 99, FA, B7, in that order.
- R7: With pat_sel=100 and I>1, the block is 221×I bytes of 00, then I bytes of 7B, then I bytes of 47. With I=1 it is 222 bytes of 00 followed by 7B.
- R8: With pat_sel=000, 101, 110 or 111, test_msg stays 0 for the whole block.
- R9: test_ready is 0 through the first full gate period. It goes to 1 on the same clock as the second rise of the gate and stays 1 until the next reset.
- R10: While rst_n is low at a clock edge, msg_gate, test_msg and test_ready are all 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, shared with the encoder |
| rst_n | input | 1 | Synchronous active-low reset |
| depth_sel | input | 2 | Interleave depth select (00→5, 01→4, 10→1, 11→5) |
| pat_sel | input | 3 | Test pattern code |
| test_msg | output | 1 | Serial test message, MSB first |
| msg_gate | output | 1 | High during message bytes, low during parity time |
| test_ready | output | 1 | High once the first flush period is complete |

## Verification
Some properties are checked on every cycle. The gate's high time must match 223×I×8 for the depth latched for that block. The message must be silent while the gate is low and whenever the code is unlisted. The latched configuration must not move during a block. Ready may rise only together with a gate rise and must never fall. The reset outputs are also checked each cycle. The byte contents of each pattern cannot be checked this way, because they depend on where the bit sits in the block. Nor can the depth decoding or the deferral of a mid-block configuration change. The bench shows these by comparing every output bit against a stream it computes itself from byte positions, for each depth and each code.

// File: rtl/rstg_pkg.sv
// Package: shared types and helpers for the RS self-test generator.
// Assumes byte-wide patterns and interleave depths of at most 5.
package rstg_pkg;

    localparam int BYTE_W = 8;
    localparam int LANE_W = 3;

    // Block phase: idle after reset, message bytes, parity time.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MSG  = 2'd1,
        PH_PAR  = 2'd2
    } phase_t;

    // Pattern codes that produce content; every other code is silent.
    localparam logic [2:0] PAT_COUNT = 3'b001;
    localparam logic [2:0] PAT_LAST  = 3'b010;
    localparam logic [2:0] PAT_TAIL  = 3'b011;
    localparam logic [2:0] PAT_PAIR  = 3'b100;

    // Decode the two-bit depth select into the interleave depth.
    function automatic logic [LANE_W-1:0] depth_of(input logic [1:0] sel);
        case (sel)
            2'b01:   return LANE_W'(4);
            2'b10:   return LANE_W'(1);
            default: return LANE_W'(5);
        endcase
    endfunction

    // Tail byte list used by the tail pattern, indexed by lane.
    function automatic logic [BYTE_W-1:0] tail_byte(input logic [LANE_W-1:0] idx);
        case (idx)
            3'd0:    return 8'h7B;
            3'd1:    return 8'hAF;
            3'd2:    return 8'h99;
            3'd3:    return 8'hFA;
            default: return 8'hB7;
        endcase
    endfunction

endpackage

// File: rtl/rstg_sequencer.sv
// Module: rstg_sequencer
// Walks through each block in a fixed order: bit, then lane (interleave
// slot), then group. The group counter covers message groups first and
// parity groups after them. Depth and pattern code are latched when a
// block starts. Assumes one bit per clock and depth >= 1.
module rstg_sequencer
    import rstg_pkg::*;
#(
    parameter int MSG_GROUPS = 223,
    parameter int PAR_GROUPS = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [1:0]                             depth_sel,
    input  logic [2:0]                             pat_sel,
    output phase_t                                 phase_o,
    output logic [$clog2((MSG_GROUPS > PAR_GROUPS) ? MSG_GROUPS : PAR_GROUPS)-1:0] grp_o,
    output logic [LANE_W-1:0]                      lane_o,
    output logic [$clog2(BYTE_W)-1:0]              bit_o,
    output logic [LANE_W-1:0]                      depth_o,
    output logic [2:0]                             pat_o,
    output logic                                   start_o
);

    localparam int CNT_MAX = (MSG_GROUPS > PAR_GROUPS) ? MSG_GROUPS : PAR_GROUPS;
    localparam int GRP_W   = $clog2(CNT_MAX);
    localparam int BIT_W   = $clog2(BYTE_W);

    phase_t             phase_q;
    logic [GRP_W-1:0]   grp_q;
    logic [LANE_W-1:0]  lane_q;
    logic [BIT_W-1:0]   bit_q;
    logic [LANE_W-1:0]  depth_q;
    logic [2:0]         pat_q;

    logic byte_last;
    logic lane_last;
    logic grp_last;
    logic start;

    // Purpose: flag the last bit, last lane and last group of the current phase.
    always_comb begin
        byte_last = (bit_q == BIT_W'(BYTE_W - 1));
        lane_last = (lane_q == depth_q - LANE_W'(1));
        if (phase_q == PH_MSG) grp_last = (grp_q == GRP_W'(MSG_GROUPS - 1));
        else                   grp_last = (grp_q == GRP_W'(PAR_GROUPS - 1));
        start = (phase_q == PH_IDLE) ||
                ((phase_q == PH_PAR) && byte_last && lane_last && grp_last);
    end

    // Purpose: advance the position counters and latch the configuration at block start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            grp_q   <= '0;
            lane_q  <= '0;
            bit_q   <= '0;
            depth_q <= LANE_W'(1);
            pat_q   <= '0;
        end else if (start) begin
            phase_q <= PH_MSG;
            grp_q   <= '0;
            lane_q  <= '0;
            bit_q   <= '0;
            depth_q <= depth_of(depth_sel);
            pat_q   <= pat_sel;
        end else if (byte_last) begin
            bit_q <= '0;
            if (lane_last) begin
                lane_q <= '0;
                if (grp_last) begin
                    grp_q   <= '0;
                    phase_q <= PH_PAR;
                end else begin
                    grp_q <= grp_q + GRP_W'(1);
                end
            end else begin
                lane_q <= lane_q + LANE_W'(1);
            end
        end else begin
            bit_q <= bit_q + BIT_W'(1);
        end
    end

    assign phase_o = phase_q;
    assign grp_o   = grp_q;
    assign lane_o  = lane_q;
    assign bit_o   = bit_q;
    assign depth_o = depth_q;
    assign pat_o   = pat_q;
    assign start_o = start;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_MSG || $past(phase_q) != PH_IDLE) && phase_q != PH_IDLE && !$past(start)
        |-> $stable(depth_q) && $stable(pat_q)); // R2

    AST_LANE_IN_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != PH_IDLE |-> lane_q < depth_q); // R2

endmodule

// File: rtl/rstg_pattern.sv
// Module: rstg_pattern
// Works out the current message byte from the group, the lane, the latched
// depth and the pattern code, then picks out one bit, MSB first. The
// output is forced to zero outside the message phase. Assumes the group
// counter counts message groups while active is high.
module rstg_pattern
    import rstg_pkg::*;
#(
    parameter int MSG_GROUPS = 223,
    parameter int GRP_W      = 8
) (
    input  logic                       active_i,
    input  logic [GRP_W-1:0]           grp_i,
    input  logic [LANE_W-1:0]          lane_i,
    input  logic [$clog2(BYTE_W)-1:0]  bit_i,
    input  logic [LANE_W-1:0]          depth_i,
    input  logic [2:0]                 pat_i,
    output logic                       bit_o
);

    localparam int BIT_W = $clog2(BYTE_W);

    logic              grp_final;
    logic              grp_before;
    logic              lane_final;
    logic              single;
    logic [BYTE_W-1:0] byte_v;

    // Purpose: find where the block tail markers sit for the current position.
    always_comb begin
        grp_final  = (grp_i == GRP_W'(MSG_GROUPS - 1));
        grp_before = (grp_i == GRP_W'(MSG_GROUPS - 2));
        lane_final = (lane_i == depth_i - LANE_W'(1));
        single     = (depth_i == LANE_W'(1));
    end

    // Purpose: choose the byte value for the selected pattern.
    always_comb begin
        case (pat_i)
            PAT_COUNT: byte_v = BYTE_W'(lane_i) + BYTE_W'(1);
            PAT_LAST:  byte_v = (grp_final && lane_final) ? 8'h7B : 8'h00;
            PAT_TAIL:  byte_v = grp_final ? tail_byte(lane_i) : 8'h00;
            PAT_PAIR: begin
                if (single)          byte_v = grp_final ? 8'h7B : 8'h00;
                else if (grp_final)  byte_v = 8'h47;
                else if (grp_before) byte_v = 8'h7B;
                else                 byte_v = 8'h00;
            end
            default:   byte_v = 8'h00;
        endcase
    end

    // Purpose: serialise MSB first and keep quiet outside the message phase.
    always_comb begin
        bit_o = active_i & byte_v[BIT_W'(BYTE_W - 1) - bit_i];
    end

endmodule

// File: rtl/rstg_ready.sv
// Module: rstg_ready
// Raises ready at the second block start after reset and holds it there.
// Assumes start_i pulses for one clock on the edge where the gate rises.
module rstg_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ready_o
);

    logic seen_q;
    logic ready_q;

    // Purpose: remember the first block start, then set ready at the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            ready_q <= 1'b0;
        end else if (start_i) begin
            seen_q  <= 1'b1;
            ready_q <= ready_q | seen_q;
        end
    end

    assign ready_o = ready_q;

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> ready_q); // R9

endmodule

// File: rtl/rs_selftest_gen.sv
// Module: rs_selftest_gen (top)
// Self-test source for an RS encoder: serial test message, message/parity
// gate and ready flag. Assumes clk is the encoder's bit clock and that the
// encoder reads one message bit per clock while the gate is high.
module rs_selftest_gen
    import rstg_pkg::*;
#(
    parameter int MSG_GROUPS = 223,
    parameter int PAR_GROUPS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] depth_sel,
    input  logic [2:0] pat_sel,
    output logic       test_msg,
    output logic       msg_gate,
    output logic       test_ready
);

    localparam int CNT_MAX = (MSG_GROUPS > PAR_GROUPS) ? MSG_GROUPS : PAR_GROUPS;
    localparam int GRP_W   = $clog2(CNT_MAX);
    localparam int BIT_W   = $clog2(BYTE_W);

    phase_t             phase;
    logic [GRP_W-1:0]   grp;
    logic [LANE_W-1:0]  lane;
    logic [BIT_W-1:0]   bitn;
    logic [LANE_W-1:0]  depth;
    logic [2:0]         pat;
    logic               start;

    rstg_sequencer #(
        .MSG_GROUPS (MSG_GROUPS),
        .PAR_GROUPS (PAR_GROUPS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth_sel (depth_sel),
        .pat_sel   (pat_sel),
        .phase_o   (phase),
        .grp_o     (grp),
        .lane_o    (lane),
        .bit_o     (bitn),
        .depth_o   (depth),
        .pat_o     (pat),
        .start_o   (start)
    );

    rstg_pattern #(
        .MSG_GROUPS (MSG_GROUPS),
        .GRP_W      (GRP_W)
    ) u_pat (
        .active_i (phase == PH_MSG),
        .grp_i    (grp),
        .lane_i   (lane),
        .bit_i    (bitn),
        .depth_i  (depth),
        .pat_i    (pat),
        .bit_o    (test_msg)
    );

    rstg_ready u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .ready_o (test_ready)
    );

    assign msg_gate = (phase == PH_MSG);

    // Checker-only counter of consecutive gate-high clocks.
    logic [31:0] run_cnt;

    // Purpose: count how long the gate has been high, for the length check.
    always_ff @(posedge clk) begin
        if (!rst_n) run_cnt <= '0;
        else        run_cnt <= msg_gate ? run_cnt + 32'd1 : 32'd0;
    end

    AST_MSG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msg_gate) |-> run_cnt == 32'(MSG_GROUPS * BYTE_W) * 32'(depth)); // R1

    AST_GATE_LOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_gate |-> !test_msg); // R3

    AST_UNLISTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pat == 3'b000 || pat > 3'b100) |-> !test_msg); // R8

    AST_READY_WITH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_ready) |-> $rose(msg_gate)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !msg_gate && !test_msg && !test_ready); // R10

endmodule

// File: tb/rs_selftest_gen_tb.sv
// Scoreboard bench: the driver pushes the expected (gate, bit, ready) for
// every clock into a queue, and the monitor pops and compares each item.
// Clock period 8 time units (125 MHz at 1 ns units).
module rs_selftest_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] depth_sel = 2'b10;
    logic [2:0] pat_sel = 3'b000;
    logic       test_msg;
    logic       msg_gate;
    logic       test_ready;

    always #4 clk = ~clk;

    rs_selftest_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .depth_sel  (depth_sel),
        .pat_sel    (pat_sel),
        .test_msg   (test_msg),
        .msg_gate   (msg_gate),
        .test_ready (test_ready)
    );

    int          checks = 0;
    int          fails  = 0;
    logic [2:0]  exp_q[$];
    bit          mon_en = 1'b0;
    string       pat_tag = "R3";
    bit          done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int depth_val(input logic [1:0] s);
        if (s == 2'b01) return 4;
        if (s == 2'b10) return 1;
        return 5;
    endfunction

    // Expected byte by position b in the block, written from R4..R8.
    function automatic int exp_byte(input int dep, input int pat, input int b);
        int n;
        n = 223 * dep;
        case (pat)
            1: return (b % dep) + 1;
            2: return (b == n - 1) ? 8'h7B : 0;
            3: begin
                if (b < 222 * dep) return 0;
                case (b - 222 * dep)
                    0: return 8'h7B;
                    1: return 8'hAF;
                    2: return 8'h99;
                    3: return 8'hFA;
                    default: return 8'hB7;
                endcase
            end
            4: begin
                if (dep == 1) return (b == n - 1) ? 8'h7B : 0;
                if (b >= 222 * dep) return 8'h47;
                if (b >= 221 * dep) return 8'h7B;
                return 0;
            end
            default: return 0;
        endcase
    endfunction

    // Driver side: push one full block (message plus parity time).
    task automatic push_frame(input logic [1:0] d, input logic [2:0] p, input int idx);
        int dep;
        logic rdy;
        dep = depth_val(d);
        rdy = (idx >= 1);
        for (int b = 0; b < 223 * dep; b++) begin
            int v;
            v = exp_byte(dep, int'(p), b);
            for (int k = 7; k >= 0; k--) exp_q.push_back({1'b1, 1'(v >> k), rdy});
        end
        for (int n = 0; n < 32 * dep * 8; n++) exp_q.push_back({1'b0, 1'b0, rdy});
    endtask

    // Monitor: compare each clock's outputs away from the active edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (mon_en && exp_q.size() > 0) begin
                logic [2:0] it;
                it = exp_q.pop_front();
                chk("R1 gate", int'(msg_gate), int'(it[2]));
                chk(pat_tag, int'(test_msg), int'(it[1]));
                chk("R9 ready", int'(test_ready), int'(it[0]));
            end
        end
    end

    // One scenario: reset, check the quiet outputs, then run the given blocks.
    task automatic run_case(input logic [1:0] d, input logic [2:0] p, input int frames,
                            input string tag, input bit chg,
                            input logic [1:0] d2, input logic [2:0] p2);
        @(negedge clk);
        mon_en = 1'b0;
        rst_n = 1'b0;
        depth_sel = d;
        pat_sel = p;
        pat_tag = tag;
        repeat (3) @(negedge clk);
        chk("R10 reset gate", int'(msg_gate), 0);
        chk("R10 reset msg", int'(test_msg), 0);
        chk("R10 reset ready", int'(test_ready), 0);
        for (int f = 0; f < frames; f++) begin
            if (chg && f > 0) push_frame(d2, p2, f);
            else              push_frame(d, p, f);
        end
        rst_n = 1'b1;
        mon_en = 1'b1;
        if (chg) begin
            repeat (100) @(negedge clk);
            depth_sel = d2;
            pat_sel = p2;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        mon_en = 1'b0;
    endtask

    initial begin
        run_case(2'b00, 3'b001, 2, "R4 count I=5",     1'b0, 2'b00, 3'b000);
        run_case(2'b01, 3'b010, 1, "R5 last I=4",      1'b0, 2'b00, 3'b000);
        run_case(2'b10, 3'b010, 2, "R5 last I=1",      1'b0, 2'b00, 3'b000);
        run_case(2'b11, 3'b011, 1, "R6 tail I=5 R2",   1'b0, 2'b00, 3'b000);
        run_case(2'b01, 3'b011, 1, "R6 tail I=4",      1'b0, 2'b00, 3'b000);
        run_case(2'b10, 3'b011, 1, "R6 tail I=1",      1'b0, 2'b00, 3'b000);
        run_case(2'b10, 3'b100, 1, "R7 pair I=1",      1'b0, 2'b00, 3'b000);
        run_case(2'b01, 3'b100, 1, "R7 pair I=4",      1'b0, 2'b00, 3'b000);
        run_case(2'b00, 3'b100, 1, "R7 pair I=5",      1'b0, 2'b00, 3'b000);
        run_case(2'b10, 3'b000, 1, "R8 code 000",      1'b0, 2'b00, 3'b000);
        run_case(2'b10, 3'b111, 1, "R8 code 111",      1'b0, 2'b00, 3'b000);
        run_case(2'b10, 3'b001, 2, "R2 deferred cfg R3", 1'b1, 2'b01, 3'b011);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1600000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule